// File: doc/BRIEF.md
# Segment Descriptor Cache

This block keeps a hidden working copy of the descriptor behind each of four segment registers: code, stack, data and extra, at indices 0, 1, 2 and 3. When the load sequencer puts a new 16-bit selector into a segment register, it presents the selector together with the 48-bit descriptor it fetched for it. The block checks that the descriptor describes a memory segment and is present. If it passes, the block latches the selector and the descriptor's base, limit and access byte into that register's entry. Every later memory reference through the segment reads these cached fields, so no descriptor is fetched again.

The contents are not visible to software. An entry changes only on a load into its own segment register. The outputs feed only the address translation logic, through four read ports. Each read port picks any entry with its own index and returns the cached fields and the decoded selector. A refused load leaves the entry as it was and raises a one-cycle fault pulse with an exception vector.

Top module: `seg_desc_cache`

## Requirements
- R1: While reset is asserted and after it is released, every entry reads as not valid, with selector, base, limit and access all zero, and the fault pulse is low with vector 0.
- R2: A load strobe with an accepted descriptor writes the addressed entry on that clock edge. From the next cycle, every read port that selects it shows valid = 1 and the new fields.
- R3: The descriptor layout is: limit in bits 15:0, 24-bit base in bits 39:16, access byte in bits 47:40. In the access byte, bit 7 is the present flag and bit 4 = 1 marks a memory segment.
- R4: A load changes only the entry named by the load index. The other three entries keep their contents.
- R5: Each read port decodes its entry's stored selector as follows: requested privilege is bits 1:0, the table indicator is bit 2, and the descriptor index is bits 15:3.
- R6: A load whose access bit 4 is 0 (system descriptor) is refused. The entry, including its selector, is unchanged, and in the next cycle the fault pulse is high with vector 13.
- R7: A load with access bit 4 = 1 and present bit 7 = 0 is refused and leaves the entry unchanged. In the next cycle the fault pulse is high with vector 11.
- R8: When a descriptor is both a system descriptor and not present, the segment-type check wins and the vector is 13.
- R9: Without a load strobe, no entry changes.
- R10: The fault pulse lasts exactly one cycle per refused load. It stays low after accepted loads and idle cycles, and the vector reads 0 whenever the pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_stb | input | 1 | Segment register load strobe |
| ld_seg | input | 2 | Segment register being loaded (0 code, 1 stack, 2 data, 3 extra) |
| ld_sel | input | 16 | Selector being loaded |
| ld_desc | input | 48 | Descriptor fetched for the selector |
| rd_seg | input | 8 | Entry index per read port, 2 bits each, port p at bits 2p+1:2p |
| rd_vld | output | 4 | Entry valid per read port |
| rd_base | output | 96 | Cached base, 24 bits per port |
| rd_limit | output | 64 | Cached limit, 16 bits per port |
| rd_acc | output | 32 | Cached access byte, 8 bits per port |
| rd_rpl | output | 8 | Requested privilege of stored selector, 2 bits per port |
| rd_ti | output | 4 | Table indicator of stored selector per port |
| rd_index | output | 52 | Descriptor index of stored selector, 13 bits per port |
| flt_stb | output | 1 | One-cycle pulse for a refused load |
| flt_vec | output | 8 | Exception vector for the pulse (13 or 11), else 0 |

## Verification
The loads are tried with four descriptor kinds: valid segment, system, not-present, and system-and-not-present. Set against each other, they separate the acceptance path from both refusal vectors and from the priority between them. Loads go to every segment index, and the read ports are rotated so that each port sees each entry. An update leaking into a neighbour entry, or a port wired to the wrong entry, then shows at once. Random selectors and field values catch a slip in the descriptor bit layout or the selector split. Idle stretches between loads show any entry that drifts without a strobe.

// File: rtl/segc_pkg.sv
package segc_pkg;
  localparam int SEL_W  = 16;
  localparam int BASE_W = 24;
  localparam int LIM_W  = 16;
  localparam int ACC_W  = 8;
  localparam int DESC_W = LIM_W + BASE_W + ACC_W;
  localparam int RPL_W  = 2;
  localparam int IDXF_W = SEL_W - RPL_W - 1;
  localparam int ACC_PRESENT = 7;
  localparam int ACC_MEMSEG  = 4;
  localparam logic [7:0] VEC_BAD_TYPE    = 8'd13;
  localparam logic [7:0] VEC_NOT_PRESENT = 8'd11;

  typedef struct packed {
    logic              vld;
    logic [SEL_W-1:0]  sel;
    logic [BASE_W-1:0] base;
    logic [LIM_W-1:0]  lim;
    logic [ACC_W-1:0]  acc;
  } entry_t;

  function automatic logic [LIM_W-1:0] desc_lim(input logic [DESC_W-1:0] d);
    return d[LIM_W-1:0];
  endfunction

  function automatic logic [BASE_W-1:0] desc_base(input logic [DESC_W-1:0] d);
    return d[LIM_W +: BASE_W];
  endfunction

  function automatic logic [ACC_W-1:0] desc_acc(input logic [DESC_W-1:0] d);
    return d[LIM_W+BASE_W +: ACC_W];
  endfunction

  function automatic logic [RPL_W-1:0] sel_rpl(input logic [SEL_W-1:0] s);
    return s[RPL_W-1:0];
  endfunction

  function automatic logic sel_ti(input logic [SEL_W-1:0] s);
    return s[RPL_W];
  endfunction

  function automatic logic [IDXF_W-1:0] sel_index(input logic [SEL_W-1:0] s);
    return s[SEL_W-1:RPL_W+1];
  endfunction
endpackage

// File: rtl/segc_check.sv
module segc_check
  import segc_pkg::*;
(
  input  logic [ACC_W-1:0] acc,
  output logic             accept,
  output logic             reject,
  output logic [7:0]       vec
);
  logic is_memseg;
  logic is_present;

  always_comb begin
    is_memseg  = acc[ACC_MEMSEG];
    is_present = acc[ACC_PRESENT];
    accept     = is_memseg && is_present;
    reject     = !accept;
    if (!is_memseg)       vec = VEC_BAD_TYPE;
    else if (!is_present) vec = VEC_NOT_PRESENT;
    else                  vec = 8'd0;
  end
endmodule

// File: rtl/segc_bank.sv
module segc_bank
  import segc_pkg::*;
#(
  parameter int N_SEG = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SEG-1:0]       wr_en,
  input  entry_t                 wr_entry,
  output entry_t [N_SEG-1:0]     ents
);
  always_ff @(posedge clk) begin
    if (rst_n)
      assert_onehot_write_R4: assert ($onehot0(wr_en))
        else $error("more than one entry written");
  end

  for (genvar i = 0; i < N_SEG; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)        ents[i] <= '0;
      else if (wr_en[i]) ents[i] <= wr_entry;
    end

    assert_written_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |=> ents[i].vld);
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[i] |=> $stable(ents[i]));
  end
endmodule

// File: rtl/segc_rdport.sv
module segc_rdport
  import segc_pkg::*;
#(
  parameter int N_SEG = 4,
  localparam int IDX_W = $clog2(N_SEG)
) (
  input  entry_t [N_SEG-1:0] ents,
  input  logic [IDX_W-1:0]   idx,
  output logic               vld,
  output logic [BASE_W-1:0]  base,
  output logic [LIM_W-1:0]   lim,
  output logic [ACC_W-1:0]   acc,
  output logic [RPL_W-1:0]   rpl,
  output logic               ti,
  output logic [IDXF_W-1:0]  index
);
  entry_t pick;

  always_comb begin
    pick  = ents[idx];
    vld   = pick.vld;
    base  = pick.base;
    lim   = pick.lim;
    acc   = pick.acc;
    rpl   = sel_rpl(pick.sel);
    ti    = sel_ti(pick.sel);
    index = sel_index(pick.sel);
  end
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import segc_pkg::*;
#(
  parameter int N_SEG = 4,
  parameter int N_RD  = 4,
  localparam int IDX_W = $clog2(N_SEG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_stb,
  input  logic [IDX_W-1:0]         ld_seg,
  input  logic [SEL_W-1:0]         ld_sel,
  input  logic [DESC_W-1:0]        ld_desc,
  input  logic [N_RD*IDX_W-1:0]    rd_seg,
  output logic [N_RD-1:0]          rd_vld,
  output logic [N_RD*BASE_W-1:0]   rd_base,
  output logic [N_RD*LIM_W-1:0]    rd_limit,
  output logic [N_RD*ACC_W-1:0]    rd_acc,
  output logic [N_RD*RPL_W-1:0]    rd_rpl,
  output logic [N_RD-1:0]          rd_ti,
  output logic [N_RD*IDXF_W-1:0]   rd_index,
  output logic                     flt_stb,
  output logic [7:0]               flt_vec
);
  logic               accept;
  logic               reject;
  logic [7:0]         chk_vec;
  logic               load_ok;
  logic               load_bad;
  logic [N_SEG-1:0]   wr_en;
  entry_t             wr_entry;
  entry_t [N_SEG-1:0] ents;

  segc_check u_check (
    .acc    (desc_acc(ld_desc)),
    .accept (accept),
    .reject (reject),
    .vec    (chk_vec)
  );

  always_comb begin
    load_ok       = ld_stb && accept;
    load_bad      = ld_stb && reject;
    wr_entry.vld  = 1'b1;
    wr_entry.sel  = ld_sel;
    wr_entry.base = desc_base(ld_desc);
    wr_entry.lim  = desc_lim(ld_desc);
    wr_entry.acc  = desc_acc(ld_desc);
    for (int i = 0; i < N_SEG; i++)
      wr_en[i] = load_ok && (ld_seg == IDX_W'(i));
  end

  segc_bank #(.N_SEG(N_SEG)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_entry (wr_entry),
    .ents     (ents)
  );

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    segc_rdport #(.N_SEG(N_SEG)) u_rd (
      .ents  (ents),
      .idx   (rd_seg[p*IDX_W +: IDX_W]),
      .vld   (rd_vld[p]),
      .base  (rd_base[p*BASE_W +: BASE_W]),
      .lim   (rd_limit[p*LIM_W +: LIM_W]),
      .acc   (rd_acc[p*ACC_W +: ACC_W]),
      .rpl   (rd_rpl[p*RPL_W +: RPL_W]),
      .ti    (rd_ti[p]),
      .index (rd_index[p*IDXF_W +: IDXF_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_stb <= 1'b0;
      flt_vec <= 8'd0;
    end else begin
      flt_stb <= load_bad;
      flt_vec <= load_bad ? chk_vec : 8'd0;
    end
  end

  assert_sys_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && !ld_desc[LIM_W+BASE_W+ACC_MEMSEG]) |=> (flt_stb && flt_vec == VEC_BAD_TYPE));
  assert_np_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && ld_desc[LIM_W+BASE_W+ACC_MEMSEG] && !ld_desc[LIM_W+BASE_W+ACC_PRESENT])
      |=> (flt_stb && flt_vec == VEC_NOT_PRESENT));
  assert_reject_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_bad |=> $stable(ents));
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_bad |=> (!flt_stb && flt_vec == 8'd0));
endmodule

// File: tb/sim_seg_desc_cache.sv
module sim_seg_desc_cache;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_stb;
  logic [1:0]  ld_seg;
  logic [15:0] ld_sel;
  logic [47:0] ld_desc;
  logic [7:0]  rd_seg;
  logic [3:0]  rd_vld;
  logic [95:0] rd_base;
  logic [63:0] rd_limit;
  logic [31:0] rd_acc;
  logic [7:0]  rd_rpl;
  logic [3:0]  rd_ti;
  logic [51:0] rd_index;
  logic        flt_stb;
  logic [7:0]  flt_vec;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  int rot    = 0;

  // reference state
  bit          m_vld [4];
  logic [15:0] m_sel [4];
  logic [23:0] m_base[4];
  logic [15:0] m_lim [4];
  logic [7:0]  m_acc [4];
  bit          e_flt;
  int          e_vec;
  int          last_wr;
  string       flt_tag;

  always #10 clk = ~clk;

  seg_desc_cache u0 (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_seg(ld_seg), .ld_sel(ld_sel),
    .ld_desc(ld_desc), .rd_seg(rd_seg), .rd_vld(rd_vld), .rd_base(rd_base),
    .rd_limit(rd_limit), .rd_acc(rd_acc), .rd_rpl(rd_rpl), .rd_ti(rd_ti),
    .rd_index(rd_index), .flt_stb(flt_stb), .flt_vec(flt_vec)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string tag, input bit was_load);
    for (int p = 0; p < 4; p++) begin
      int i;
      string et;
      i  = int'(rd_seg[p*2 +: 2]);
      et = (i == last_wr) ? "R2" : (was_load ? "R4" : tag);
      chk(et, "valid", rd_vld[p], m_vld[i]);
      chk(i == last_wr ? "R3" : et, "base", rd_base[p*24 +: 24], m_base[i]);
      chk(i == last_wr ? "R3" : et, "limit", rd_limit[p*16 +: 16], m_lim[i]);
      chk(i == last_wr ? "R3" : et, "access", rd_acc[p*8 +: 8], m_acc[i]);
      chk(tag == "R1" ? "R1" : "R5", "rpl", rd_rpl[p*2 +: 2], m_sel[i][1:0]);
      chk(tag == "R1" ? "R1" : "R5", "ti", rd_ti[p], m_sel[i][2]);
      chk(tag == "R1" ? "R1" : "R5", "index", rd_index[p*13 +: 13], m_sel[i][15:3]);
    end
    chk(flt_tag, "fault pulse", flt_stb, e_flt);
    chk(flt_tag, "fault vector", flt_vec, e_vec);
  endtask

  task automatic step(input bit stb, input int seg, input logic [15:0] sel,
                      input logic [47:0] desc, input string tag);
    logic [7:0] a;
    ld_stb  = stb;
    ld_seg  = 2'(seg);
    ld_sel  = sel;
    ld_desc = desc;
    for (int p = 0; p < 4; p++) rd_seg[p*2 +: 2] = 2'((p + rot) % 4);
    rot++;
    @(posedge clk);
    a = desc[47:40];
    last_wr = -1;
    e_flt = 0;
    e_vec = 0;
    flt_tag = stb ? "R10" : "R9";
    if (stb) begin
      if (!a[4]) begin
        e_flt = 1; e_vec = 13; flt_tag = a[7] ? "R6" : "R8";
      end else if (!a[7]) begin
        e_flt = 1; e_vec = 11; flt_tag = "R7";
      end else begin
        m_vld[seg] = 1; m_sel[seg] = sel; m_base[seg] = desc[39:16];
        m_lim[seg] = desc[15:0]; m_acc[seg] = a; last_wr = seg;
      end
    end
    @(negedge clk);
    compare(e_flt ? flt_tag : tag, stb);
  endtask

  function automatic logic [47:0] mk_desc(input int kind);
    logic [47:0] d;
    d = {16'($urandom), 32'($urandom)};
    case (kind)
      0: d[44] = 1'b0;
      1: begin d[44] = 1'b1; d[47] = 1'b0; end
      2: begin d[44] = 1'b0; d[47] = 1'b0; end
      default: begin d[44] = 1'b1; d[47] = 1'b1; end
    endcase
    return d;
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #4ms;
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_vld[i] = 0; m_sel[i] = '0; m_base[i] = '0; m_lim[i] = '0; m_acc[i] = '0;
    end
    e_flt = 0; e_vec = 0; last_wr = -1; flt_tag = "R1";
    rst_n = 1'b0; ld_stb = 1'b0; ld_seg = '0; ld_sel = '0; ld_desc = '0; rd_seg = 8'hE4;
    repeat (3) @(negedge clk);
    compare("R1", 0);
    rst_n = 1'b1;
    step(0, 0, 16'h0, 48'h0, "R1");
    // fill each entry with a valid segment descriptor
    step(1, 0, 16'h0013, 48'h9A_123456_FFFF, "R2");
    step(1, 1, 16'h002E, 48'h92_00ABCD_0FFF, "R2");
    step(1, 2, 16'hFFF9, 48'hF2_FEDCBA_8001, "R2");
    step(1, 3, 16'h1234, 48'h96_010203_0000, "R2");
    step(0, 0, 16'hBEEF, 48'h0, "R9");
    // refusals on the data entry
    step(1, 2, 16'h5555, 48'h82_111111_1111, "R6");
    step(1, 2, 16'h6666, 48'h1A_222222_2222, "R7");
    step(1, 2, 16'h7777, 48'h02_333333_3333, "R8");
    step(0, 2, 16'h0, 48'h0, "R9");
    // reload of the code entry
    step(1, 0, 16'h8007, 48'h9B_000001_0001, "R2");
    for (int n = 0; n < 300; n++) begin
      int kind = int'($urandom % 6);
      bit stb  = ($urandom % 4) != 0;
      step(stb, int'($urandom % 4), 16'($urandom), mk_desc(kind), stb ? "R4" : "R9");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule